// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the bus-side half of a 2048-byte serial memory. It sits on an I2C two-wire bus as a slave. It watches the clock and data lines by oversampling them on a faster system clock, and it recognises START and STOP conditions. It answers only to the device identifier 1010. It pulls the data line low through an open-drain enable whenever it acknowledges a byte or sends a zero bit. The storage array is held in internal registers.

Writes land in a 16-byte page buffer first. The array is updated only when the master sends STOP. The slave then enters a busy period of programmable length and acknowledges nothing during it, so a master can poll until the write has finished. For reads, the slave holds an internal address pointer that always points one past the last byte it touched. A read can therefore continue from that pointer, start at an address set by a dummy write, or stream through the whole array.

Every acknowledge the slave drives also produces a one-clock strobe, which a watchdog elsewhere on the chip can use as proof of bus activity.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, `sda_pull` and `ack_strobe` are 0 and every array byte reads 0xFF.
- R2: The slave answers an address byte only if bits 7:4 are 1010. For any other value it does not acknowledge and ignores the bus until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bytes clocked in without a preceding START get no acknowledge.
- R4: In a write address byte, bits 3:1 are address bits 10:8 and bit 0 = 0 selects write. The next byte is address bits 7:0, and the following bytes are data. The slave acknowledges each of these bytes on the ninth clock.
- R5: Successive data bytes of one write go to addresses whose low 4 bits increment modulo 16, with bits 10:4 fixed. More than 16 bytes overwrite the earlier ones in the page.
- R6: Buffered data is written to the array at STOP. A START received before that STOP discards the buffered data. After a committing STOP, the slave acknowledges nothing and ignores START for BUSY_CYCLES clocks.
- R7: The address pointer holds the last written or read address plus one. A read address byte (bit 0 = 1) ignores its bits 3:1 and reads from the pointer.
- R8: A random read is a write address byte plus word address, then a repeated START and a read address byte. It returns the byte at the address that was set.
- R9: Read data leaves MSB first and changes after SCL falls. Each master acknowledge sends the next byte, with all 11 address bits incrementing and wrapping from 0x7FF to 0x000.
- R10: A missing master acknowledge ends the read. The slave then leaves SDA released until the next START.
- R11: `ack_strobe` is high for exactly one clock per acknowledge the slave drives, and at no other time.
- R12: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 = drive the data line low (open-drain enable) |
| ack_strobe | output | 1 | One-clock pulse per acknowledge given |

## Verification
The identifier sweep sends every non-matching upper nibble, which separates correct address matching from a decoder that acknowledges too eagerly. A second sweep writes one byte under each of the eight upper-address codes and reads it back by random read; this exposes swapped or dropped upper-address bits. Page writes at a page start, at mid-page offsets and with 20 and 33 bytes are read back sequentially. These show whether the increment stays inside the page and whether the overflow overwrites the right bytes. A read run across 0x7FF, current-address reads after a write and after a read, polling during the busy window, and a write aborted by a repeated START tell apart the pointer, wrap, commit and busy rules.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int BUSY_CYCLES = 400,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull,
  output logic ack_strobe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BW     = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ADR_ONE = 1;
  localparam logic [PAGE_W-1:0] PG_ONE  = 1;
  localparam logic [BW-1:0]     BUSY_LD = BW'(BUSY_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {K_DEV, K_WADR, K_WDAT, K_READ} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, scl_s, sda_s;
  state_t state;
  kind_t kind;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0] hi;
  logic [PAGE_N-1:0] pval;
  logic [7:0] pbuf [PAGE_N];
  logic [7:0] mem [DEPTH];
  logic [BW-1:0] busy_cnt;
  logic mack, wr_busy;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];
  assign wr_busy = busy_cnt != '0;

  wire start_ev  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire byte_done = (state == S_RX) & scl_fall & (cnt == 4'd8);
  wire commit    = stop_ev & (|pval);
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= K_DEV;
      cnt        <= '0;
      sh         <= '0;
      ptr        <= '0;
      hi         <= '0;
      pval       <= '0;
      mack       <= 1'b0;
      sda_pull   <= 1'b0;
      ack_strobe <= 1'b0;
    end else begin
      ack_strobe <= 1'b0;
      if (start_ev) begin
        state    <= wr_busy ? S_IDLE : S_RX;
        kind     <= K_DEV;
        cnt      <= '0;
        pval     <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= S_IDLE;
        pval     <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt        <= '0;
              state      <= S_ACK;
              sda_pull   <= 1'b1;
              ack_strobe <= 1'b1;
              case (kind)
                K_DEV: begin
                  if (sh[7:4] != DEV_ID) begin
                    state      <= S_IDLE;
                    sda_pull   <= 1'b0;
                    ack_strobe <= 1'b0;
                  end else if (sh[0]) begin
                    kind <= K_READ;
                  end else begin
                    kind <= K_WADR;
                    hi   <= sh[HI_W:1];
                  end
                end
                K_WADR: begin
                  ptr  <= {hi, sh};
                  kind <= K_WDAT;
                end
                default: begin
                  pval[ptr[PAGE_W-1:0]] <= 1'b1;
                  ptr[PAGE_W-1:0]       <= ptr[PAGE_W-1:0] + PG_ONE;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_READ) begin
                state    <= S_TX;
                sh       <= rd_byte;
                ptr      <= ptr + ADR_ONE;
                sda_pull <= ~rd_byte[7];
              end else begin
                state    <= S_RX;
                sda_pull <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state    <= S_MACK;
                sda_pull <= 1'b0;
              end else begin
                cnt      <= cnt + 4'd1;
                sh       <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state    <= S_TX;
                cnt      <= '0;
                sh       <= rd_byte;
                ptr      <= ptr + ADR_ONE;
                sda_pull <= ~rd_byte[7];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done && kind == K_WDAT)
      pbuf[ptr[PAGE_W-1:0]] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (pval[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_cnt <= '0;
    else if (commit)  busy_cnt <= BUSY_LD;
    else if (wr_busy) busy_cnt <= busy_cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic ack_strobe,
  input logic wr_busy
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |=> !ack_strobe); // R11
  AST_STROBE_WITH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |-> sda_pull); // R11
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !ack_strobe); // R6
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s); // R12
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s),
  .sda_pull(sda_pull), .ack_strobe(ack_strobe), .wr_busy(wr_busy)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  localparam int BUSY = 400;
  localparam int H = 10;
  localparam int G = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_pull, ack_strobe;
  wire sda_bus = ~(m_low | sda_pull);
  int errors = 0, checks = 0, cyc = 0;
  int slave_acks = 0, st_hi = 0, st_rise = 0, pull_viol = 0;
  logic st_prev = 1'b0, pull_prev = 1'b0;
  logic [7:0] model [2048];

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull(sda_pull), .ack_strobe(ack_strobe)
  );

  always @(negedge clk) begin
    if (ack_strobe) st_hi++;
    if (ack_strobe && !st_prev) st_rise++;
    st_prev = ack_strobe;
    if (sda_pull != pull_prev && scl) pull_viol++;
    pull_prev = sda_pull;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H); m_low = 1'b1; tick(H); scl = 1'b0; tick(G);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; tick(H); scl = 1'b1; tick(H); m_low = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(G);
    end
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H/2);
    ack = ~sda_bus;
    if (ack) slave_acks++;
    tick(H/2); scl = 1'b0; tick(G);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 1'b0; tick(G);
    end
    m_low = give_ack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(G); m_low = 1'b0;
  endtask

  task automatic write_seq(input logic [10:0] a, input int n, input logic [7:0] seed,
                           input logic wait_done, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte({4'hA, a[10:8], 1'b0}, ack); chk(tag, ack, 1);
    send_byte(a[7:0], ack); chk(tag, ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + 8'(k * 29));
      send_byte(d, ack); chk(tag, ack, 1);
      model[{a[10:4], 4'(a[3:0] + 4'(k))}] = d;
    end
    bus_stop;
    if (wait_done) tick(BUSY + 50);
  endtask

  task automatic read_seq(input logic [10:0] a, input int n, input logic rnd, input string tag);
    logic ack;
    logic [7:0] d;
    if (rnd) begin
      bus_start;
      send_byte({4'hA, a[10:8], 1'b0}, ack); chk(tag, ack, 1);
      send_byte(a[7:0], ack); chk(tag, ack, 1);
    end
    bus_start;
    send_byte(8'hAB, ack); chk(tag, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(tag, d, model[11'(a + 11'(k))]);
    end
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    tick(5);
    chk("R1 reset pull", sda_pull, 0);
    chk("R1 reset strobe", ack_strobe, 0);
    rst_n = 1'b1; tick(5);
    chk("R1 idle pull", sda_pull, 0);

    send_byte(8'hA0, ack); chk("R3 no start", ack, 0);
    bus_stop;

    for (int id = 0; id < 16; id++) begin
      if (id != 10) begin
        bus_start;
        send_byte({4'(id), 4'b0000}, ack); chk("R2 foreign id", ack, 0);
        bus_stop;
      end
    end

    read_seq(11'h555, 1, 1'b1, "R1 erased");

    for (int h = 0; h < 8; h++)
      write_seq({3'(h), 8'hC0 | 8'(h)}, 1, 8'(h * 17 + 3), 1'b1, "R4 write");
    for (int h = 0; h < 8; h++)
      read_seq({3'(h), 8'hC0 | 8'(h)}, 1, 1'b1, "R4 readback");

    write_seq(11'h123, 1, 8'h5C, 1'b0, "R4 byte");
    bus_start;
    send_byte(8'hA0, ack); chk("R6 busy poll", ack, 0);
    bus_stop;
    tick(BUSY + 50);
    bus_start;
    send_byte(8'hA0, ack); chk("R6 done poll", ack, 1);
    bus_stop;
    read_seq(11'h123, 1, 1'b1, "R8 random");

    write_seq(11'h000, 16, 8'h10, 1'b1, "R5 full page");
    write_seq(11'h3A5, 5, 8'h40, 1'b1, "R5 mid page");
    read_seq(11'h3AA, 2, 1'b0, "R7 after write");
    write_seq(11'h7F8, 20, 8'h80, 1'b1, "R5 overflow");
    write_seq(11'h456, 1, 8'hE1, 1'b1, "R5 single");
    write_seq(11'h21C, 33, 8'h33, 1'b1, "R5 double wrap");
    read_seq(11'h000, 16, 1'b1, "R5 read");
    read_seq(11'h3A0, 16, 1'b1, "R5 read");
    read_seq(11'h210, 16, 1'b1, "R5 read");
    read_seq(11'h450, 16, 1'b1, "R5 read");

    read_seq(11'h7F0, 20, 1'b1, "R9 wrap");
    read_seq(11'h004, 3, 1'b0, "R7 after read");

    bus_start;
    send_byte(8'hA0, ack); chk("R6 abort", ack, 1);
    send_byte(8'h80, ack); chk("R6 abort", ack, 1);
    send_byte(8'h11, ack); chk("R6 abort", ack, 1);
    bus_start;
    send_byte(8'hA1, ack); chk("R6 abort restart", ack, 1);
    recv_byte(1'b0, d); chk("R6 abort ptr", d, model[11'h081]);
    bus_stop;
    bus_start;
    send_byte(8'hA0, ack); chk("R6 no commit", ack, 1);
    send_byte(8'h80, ack); chk("R6 no commit", ack, 1);
    bus_start;
    send_byte(8'hA1, ack); chk("R6 no commit", ack, 1);
    recv_byte(1'b0, d); chk("R6 discarded", d, model[11'h080]);
    bus_stop;

    bus_start;
    send_byte(8'hA0, ack); chk("R10 setup", ack, 1);
    send_byte(8'h00, ack); chk("R10 setup", ack, 1);
    bus_start;
    send_byte(8'hA1, ack); chk("R10 setup", ack, 1);
    recv_byte(1'b0, d); chk("R10 data", d, model[11'h000]);
    for (int p = 0; p < 9; p++) begin
      tick(H); scl = 1'b1; tick(H/2);
      chk("R10 released", sda_bus, 1);
      tick(H/2); scl = 1'b0; tick(G);
    end
    bus_stop;

    chk("R11 width", st_hi, st_rise);
    chk("R11 count", st_rise, slave_acks);
    chk("R12 change while SCL high", pull_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule